// File: doc/BRIEF.md
# Pipelined No-Turnaround Burst SRAM

A synchronous static RAM model that keeps its data bus busy on every cycle, whatever the mix of reads and writes. A command is taken on a rising clock edge. A read returns its word two edges later. A write takes its data two edges after its address, so the write-data slot lines up with the read-data slot. Reads and writes can then follow each other on consecutive cycles with no idle cycle between them. The word is split into eight 9-bit lanes (8 data bits plus 1 parity bit), and each lane has its own active-low write enable.

After a command has loaded an address, further cycles with the advance input high continue a 4-beat burst. The next addresses are produced internally in linear or interleaved order. A clock-enable input freezes the whole machine, including any operations still in the pipeline. A sleep input, synchronised over two edges, parks the device with its contents kept. The read path has a data bus plus a drive-enable output, gated at once by an asynchronous output enable. The array depth is set by an address-width parameter, so the model can be simulated small.

Top module: `nt_burst_sram`

## Requirements
- R1: A new operation is loaded only at an edge where cke_n=0, adv=0, cs1_n=0, cs2=1 and cs3_n=0. rw=1 selects a read and rw=0 a write. After reset nothing is driven (rdata_oe=0).
- R2: A read loaded at edge k shows the word on rdata with rdata_oe=1 (when oe_n=0) from edge k+2 until the next enabled edge.
- R3: For a write loaded at edge k, wdata is sampled at edge k+2. Lane i is wdata[9i+8:9i] and is written only when bwe_n[i]=0, with bwe_n taken together with the address.
- R4: With adv=1 after a read or write, the next beat of the same kind runs at an internal address. Upper address bits stay fixed, and the two low bits wrap back to the seed after four beats.
- R5: With order_sel=0, beat n uses low bits (seed+n) mod 4. With order_sel=1, it uses seed XOR n.
- R6: While cke_n=1 every input except sleep and oe_n is ignored. No write lands, no burst moves, and rdata/rdata_oe hold their values.
- R7: A write beat whose bwe_n is all ones changes no lane, and it aborts only that beat of the burst.
- R8: With adv=0 and any chip select inactive, the device is deselected. Later cycles with adv=1 keep it deselected, with no drive and no write.
- R9: rdata_oe is high only for read data with oe_n low, and it follows oe_n without waiting for a clock edge.
- R10: A sleep level seen at edge k makes commands ignored from edge k+2 on, with rdata_oe low and contents kept. After sleep falls, commands are accepted again two edges later.
- R11: A read whose array access overlaps a write of the same address that is still in flight returns the new data, merged lane by lane according to that write's enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a command, 1 continues the burst |
| rw | input | 1 | 1 read, 0 write |
| bwe_n | input | 8 | Per-lane write enables, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| addr | input | ADDR_W | Word address |
| wdata | input | 72 | Write data, eight 9-bit lanes |
| rdata | output | 72 | Read data |
| rdata_oe | output | 1 | High when rdata is to be driven |

## Verification
A wrong burst counter or a wrong order function shows up as a wrong word on rdata two edges after the faulty beat. A slip in the write pipeline stage corrupts the array without any sign until that address is read again. The random phase therefore reads back soon after writing. A missing or wrong forward path shows up only when a read follows a write to the same word by exactly one cycle, so that case is driven directly. A clock-enable leak shows up as a changed rdata while frozen, or as a beat shifted in a burst that resumes after a freeze.

// File: rtl/nt_pkg.sv
package nt_pkg;
    localparam int LANES  = 8;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] lane_n;
    } cmd_t;

    // low address bits for beat n of a burst
    function automatic logic [1:0] beat_low(input logic [1:0] seed,
                                            input logic [1:0] beat,
                                            input logic       interleave);
        return interleave ? (seed ^ beat) : (seed + beat);
    endfunction

    // replace the lanes whose active-low enable is set
    function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] base_w,
                                                     input logic [WORD_W-1:0] new_w,
                                                     input logic [LANES-1:0]  en_n);
        logic [WORD_W-1:0] r;
        r = base_w;
        for (int i = 0; i < LANES; i++)
            if (!en_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        return r;
    endfunction
endpackage

// File: rtl/nt_cmd_ctrl.sv
module nt_cmd_ctrl
    import nt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              asleep,
    input  logic              sel,
    input  logic              adv,
    input  logic              rw,
    input  logic              order_sel,
    input  logic [LANES-1:0]  bwe_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int HI_W = ADDR_W - 2;

    op_e             cur_op;
    logic [HI_W-1:0] base_hi;
    logic [1:0]      seed;
    logic [1:0]      beat;
    logic [1:0]      next_beat;

    assign next_beat = beat + 2'd1;

    always_comb begin
        cmd.op   = OP_IDLE;
        cmd_addr = addr;
        if (asleep) begin
            cmd.op = OP_IDLE;
        end else if (!adv) begin
            cmd.op = sel ? (rw ? OP_READ : OP_WRITE) : OP_IDLE;
        end else begin
            cmd.op   = cur_op;
            cmd_addr = {base_hi, beat_low(seed, next_beat, order_sel)};
        end
        cmd.lane_n = (cmd.op == OP_WRITE) ? bwe_n : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_op  <= OP_IDLE;
            base_hi <= '0;
            seed    <= '0;
            beat    <= '0;
        end else if (step) begin
            cur_op <= cmd.op;
            if (!asleep && !adv) begin
                base_hi <= addr[ADDR_W-1:2];
                seed    <= addr[1:0];
                beat    <= '0;
            end else if (!asleep && cur_op != OP_IDLE) begin
                beat <= next_beat;
            end
        end
    end

    // R4: an enabled continue cycle moves the beat counter by exactly one
    a_r4_beat_steps: assert property (@(posedge clk) disable iff (rst)
        (step && adv && !asleep && cur_op != OP_IDLE) |=> beat == $past(beat) + 2'd1);
endmodule

// File: rtl/nt_store.sv
module nt_store
    import nt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wlane_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] arr_word;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= lane_merge(mem[waddr], wdata, wlane_n);
    end

    // a write landing on this same edge is forwarded into the read
    assign arr_word = mem[raddr];
    assign rword    = (we && waddr == raddr) ? lane_merge(arr_word, wdata, wlane_n) : arr_word;
endmodule

// File: rtl/nt_burst_sram.sv
module nt_burst_sram
    import nt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              adv,
    input  logic              rw,
    input  logic [7:0]        bwe_n,
    input  logic              order_sel,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [71:0]       wdata,
    output logic [71:0]       rdata,
    output logic              rdata_oe
);
    localparam int SLEEP_SYNC = 2;

    logic [SLEEP_SYNC-1:0] sleep_sync;
    logic                  asleep;
    logic                  step;
    logic                  sel;
    cmd_t                  cmd;
    logic [ADDR_W-1:0]     cmd_addr;
    cmd_t                  p1, p2;
    logic [ADDR_W-1:0]     p1_addr, p2_addr;
    logic [WORD_W-1:0]     rword, mid_data, out_data;
    logic                  out_vld;

    assign step   = !cke_n;
    assign sel    = !cs1_n && cs2 && !cs3_n;
    assign asleep = sleep_sync[SLEEP_SYNC-1];

    always_ff @(posedge clk) begin
        if (rst) sleep_sync <= '0;
        else     sleep_sync <= {sleep_sync[SLEEP_SYNC-2:0], sleep};
    end

    nt_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .step(step), .asleep(asleep), .sel(sel),
        .adv(adv), .rw(rw), .order_sel(order_sel), .bwe_n(bwe_n), .addr(addr),
        .cmd(cmd), .cmd_addr(cmd_addr)
    );

    nt_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(step && p2.op == OP_WRITE), .waddr(p2_addr),
        .wlane_n(p2.lane_n), .wdata(wdata), .raddr(p1_addr), .rword(rword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p1       <= '{op: OP_IDLE, lane_n: '1};
            p2       <= '{op: OP_IDLE, lane_n: '1};
            p1_addr  <= '0;
            p2_addr  <= '0;
            mid_data <= '0;
            out_data <= '0;
            out_vld  <= 1'b0;
        end else if (step) begin
            p1       <= cmd;
            p1_addr  <= cmd_addr;
            p2       <= p1;
            p2_addr  <= p1_addr;
            mid_data <= rword;
            out_data <= mid_data;
            out_vld  <= (p2.op == OP_READ);
        end
    end

    assign rdata    = out_data;
    assign rdata_oe = out_vld && !oe_n && !asleep;

    // R6: a frozen clock enable leaves the output stage and pipeline untouched
    a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(out_data) && $stable(out_vld) && $stable(p2.op)));

    // R2: a read in the second stage reaches the output register on the next enabled edge
    a_r2_read_reaches_out: assert property (@(posedge clk) disable iff (rst)
        (step && p2.op == OP_READ) |=> out_vld);

    // R10: no command leaves the controller while asleep
    a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
        asleep |-> cmd.op == OP_IDLE);
endmodule

// File: tb/sim_nt_burst_sram.sv
module sim_nt_burst_sram;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke_n = 1'b0, cs1_n = 1'b1, cs2 = 1'b1, cs3_n = 1'b0, adv = 1'b0, rw = 1'b1;
    logic [7:0] bwe_n = 8'hFF;
    logic order_sel = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [71:0] wdata = '0;
    logic [71:0] rdata;
    logic rdata_oe;

    always #5 clk = ~clk;

    nt_burst_sram #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .adv(adv), .rw(rw), .bwe_n(bwe_n), .order_sel(order_sel), .oe_n(oe_n),
        .sleep(sleep), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    typedef struct { int kind; int a; logic [7:0] be; } ent_t;   // kind 0 none, 1 read, 2 write

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    logic [71:0] rmem [DEPTH];
    ent_t pq[$];
    bit m_sl1 = 0, m_sl2 = 0, exp_vld = 0;
    logic [71:0] exp_data = '0;
    int m_kind = 0, m_base = 0, m_seed = 0, m_cnt = 0;

    task automatic chk(input bit ok, input logic [71:0] act, input logic [71:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // behavioural reference for one rising edge, using the inputs now applied
    task automatic model_edge();
        bit asl;
        ent_t e, old;
        asl = m_sl2;
        m_sl2 = m_sl1;
        m_sl1 = sleep;
        if (!cke_n) begin
            old = pq.pop_front();
            exp_vld = (old.kind == 1);
            if (old.kind == 1) exp_data = rmem[old.a];
            if (old.kind == 2)
                for (int i = 0; i < 8; i++)
                    if (!old.be[i]) rmem[old.a][i*9 +: 9] = wdata[i*9 +: 9];
            e = '{0, 0, 8'hFF};
            if (asl) m_kind = 0;
            else if (!adv) begin
                if (!cs1_n && cs2 && !cs3_n) begin
                    m_kind = rw ? 1 : 2;
                    m_base = int'(addr); m_seed = int'(addr) % 4; m_cnt = 0;
                    e = '{m_kind, int'(addr), bwe_n};
                end else m_kind = 0;
            end else if (m_kind != 0) begin
                int idx;
                m_cnt = (m_cnt + 1) % 4;
                idx = order_sel ? (m_seed ^ m_cnt) : ((m_seed + m_cnt) % 4);
                e = '{m_kind, (m_base / 4) * 4 + idx, bwe_n};
            end
            if (e.kind != 2) e.be = 8'hFF;
            pq.push_back(e);
        end
    endtask

    task automatic compare();
        bit eoe;
        eoe = exp_vld && !oe_n && !m_sl2;
        chk(rdata_oe == eoe, {71'd0, rdata_oe}, {71'd0, eoe}, "rdata_oe");
        if (eoe) chk(rdata == exp_data, rdata, exp_data, "rdata");
    endtask

    task automatic cyc();
        wdata = {$urandom, $urandom, $urandom};
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic ld(input bit rd, input int a, input logic [7:0] be);
        cs1_n = 0; cs2 = 1; cs3_n = 0; adv = 0; rw = rd; addr = AW'(a); bwe_n = be;
        cyc();
    endtask

    task automatic cont(input logic [7:0] be);
        adv = 1; bwe_n = be; addr = AW'($urandom);
        cyc();
    endtask

    task automatic desel(input int n);
        for (int i = 0; i < n; i++) begin
            cs1_n = 1; adv = 0; cyc();
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) rmem[i] = '0;
        pq.push_back('{0, 0, 8'hFF});
        pq.push_back('{0, 0, 8'hFF});
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R1";
        chk(rdata_oe == 1'b0, {71'd0, rdata_oe}, 72'd0, "reset drive");

        cur_req = "R3";   // fill every word, back to back
        for (int i = 0; i < DEPTH; i++) ld(0, i, 8'h00);
        desel(2);

        cur_req = "R2";
        ld(1, 3, 8'h00); ld(1, 40, 8'h00); desel(1); ld(1, 17, 8'h00); desel(3);

        cur_req = "R3";   // partial lanes
        ld(0, 9, 8'hA5); desel(2); ld(1, 9, 8'h00); desel(3);

        cur_req = "R11";  // read right behind a write of the same word
        ld(0, 12, 8'h0F); ld(1, 12, 8'h00); ld(0, 13, 8'h00); ld(1, 13, 8'h00);
        ld(0, 12, 8'hF0); ld(1, 12, 8'h00); ld(1, 12, 8'h00); desel(3);

        cur_req = "R4";
        order_sel = 0; ld(1, 22, 8'h00); cont(8'h00); cont(8'h00); cont(8'h00); cont(8'h00); desel(3);
        cur_req = "R5";
        order_sel = 1; ld(1, 31, 8'h00); cont(8'h00); cont(8'h00); cont(8'h00); desel(3);
        order_sel = 0; ld(0, 45, 8'h00); cont(8'h00); cont(8'h00); cont(8'h00);
        order_sel = 1; ld(1, 45, 8'h00); cont(8'h00); cont(8'h00); cont(8'h00); desel(3);

        cur_req = "R7";   // abort only the third beat
        order_sel = 0; ld(0, 49, 8'h00); cont(8'h00); cont(8'hFF); cont(8'h00);
        ld(1, 48, 8'h00); cont(8'h00); cont(8'h00); cont(8'h00); desel(3);

        cur_req = "R6";   // freeze mid burst with data in flight
        ld(1, 4, 8'h00); cont(8'h00);
        cke_n = 1; ld(0, 5, 8'h00); ld(0, 6, 8'h00); cont(8'h00);
        cke_n = 0; cont(8'h00); cont(8'h00);
        ld(0, 7, 8'h00); cke_n = 1; desel(2); cke_n = 0; desel(2); ld(1, 7, 8'h00); desel(3);

        cur_req = "R8";
        desel(1); cont(8'h00); cont(8'h00); cont(8'h00);
        cs1_n = 0; cs2 = 0; adv = 0; rw = 0; addr = 6'd10; bwe_n = 0; cyc();
        cs2 = 1; cs3_n = 1; rw = 1; cyc(); cs3_n = 0; cont(8'h00); desel(2);
        ld(1, 10, 8'h00); desel(3);

        cur_req = "R9";
        oe_n = 1; ld(1, 2, 8'h00); ld(1, 3, 8'h00); desel(1);
        oe_n = 0; #1;
        chk(rdata_oe == 1'b1, {71'd0, rdata_oe}, 72'd1, "oe async low");
        oe_n = 1; #1;
        chk(rdata_oe == 1'b0, {71'd0, rdata_oe}, 72'd0, "oe async high");
        oe_n = 0; desel(3);

        cur_req = "R10";
        ld(1, 20, 8'h00); sleep = 1; ld(1, 21, 8'h00);
        ld(0, 20, 8'h00); ld(0, 21, 8'h00); ld(1, 20, 8'h00); desel(2);
        sleep = 0; ld(1, 21, 8'h00); ld(1, 20, 8'h00); ld(1, 21, 8'h00); desel(3);

        cur_req = "R1";   // random traffic, reads check everything written
        for (int i = 0; i < 4000; i++) begin
            cke_n = ($urandom % 8 == 0);
            sleep = ((i % 500) >= 470);
            oe_n = ($urandom % 6 == 0);
            if (i % 40 == 0) order_sel = $urandom;
            cs1_n = ($urandom % 10 == 0); cs2 = 1; cs3_n = 0;
            adv = ($urandom % 2); rw = $urandom;
            bwe_n = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            addr = AW'($urandom);
            cyc();
        end
        cke_n = 0; sleep = 0; oe_n = 0;
        desel(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule